// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over 32 clock cycles and returns a 64-bit product. It uses one adder of operand width and a single double-width product register. The multiplier operand is loaded into the low half of that register. Each step shifts out one multiplier bit and shifts in one product bit, so the multiplier and the product share the same storage.

A client pulses `start` while the block is idle. The operands and a signed/unsigned selector are sampled on that edge. `busy` stays high for exactly 32 cycles. `done` then pulses for one cycle, and from that cycle on the upper and lower product words are valid on `prodHi` and `prodLo`. They hold until the next accepted start.

Signed operation accumulates sign-extended partial products with an arithmetic right shift. If the multiplier is negative, both operands are negated at load, because M×Q = (−M)×(−Q). The multiplicand keeps one extra sign bit so that negating the most negative value stays exact.

Top module: `seq_mul`

## Requirements
- R1: While reset is held and after its release, `busy` and `done` are 0 and `prodHi`/`prodLo` read 0.
- R2: A `start` pulse sampled while `busy` is 0 captures `mcandIn`, `mplierIn` and `signedMode`, and `busy` reads 1 from the next cycle.
- R3: `busy` is 1 for exactly 32 cycles after an accepted start. `done` is 1 for exactly one cycle, in the first cycle with `busy` back at 0.
- R4: With `signedMode` = 0 both operands are unsigned. {prodHi, prodLo} equals the full 64-bit product, including all-ones times all-ones, where every add carries out.
- R5: With `signedMode` = 1 both operands are two's complement. With a negative multiplicand and a non-negative multiplier, the result is the correct signed 64-bit product.
- R6: With `signedMode` = 1 and a negative multiplier, the result is the correct signed product. This includes operands equal to the most negative value 0x80000000.
- R7: `start` and any operand or mode change while `busy` is 1 have no effect: the running operation finishes on time with the product of the captured operands.
- R8: After `done`, `prodHi` and `prodLo` stay constant until the next accepted start.
- R9: The mode is taken only from the start cycle. The same bit patterns give different results in the two modes (e.g. 0xFFFFFFFF × 2 gives 0x1_FFFFFFFE unsigned and −2 signed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication when idle |
| signedMode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mcandIn | input | 32 | Multiplicand |
| mplierIn | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prodHi | output | 32 | Upper half of the product |
| prodLo | output | 32 | Lower half of the product |

## Verification
The bench targets four failure modes:

- **All-ones unsigned operands.** If the adder's carry-out were dropped instead of being shifted into the top bit, the high word would come out too small.
- **Mixed-sign signed pairs.** With a logical shift instead of an arithmetic one, a negative multiplicand would give a large positive high word.
- **The most negative value as either operand.** Without the extra multiplicand sign bit, negating it wraps, and 0x80000000 squared would come out negative.
- **Start pulses and operand changes injected mid-operation.** A design that reloaded on them would finish late or return the wrong operands' product. A late or doubled `done` pulse shows up in the cycle-by-cycle comparison of `busy` and `done`.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } mulStrobes_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNTW = $clog2(WIDTH + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(WIDTH - 1);

  logic [CNTW-1:0] stepCnt;
  logic            busyQ;
  logic            doneQ;

  always_comb begin
    strobes.load = start & ~busyQ;
    strobes.step = busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneQ <= 1'b0;
      if (strobes.load) begin
        busyQ   <= 1'b1;
        stepCnt <= '0;
      end else if (busyQ) begin
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == LAST) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobes_t      strobes,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] mcandIn,
  input  logic [WIDTH-1:0] mplierIn,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandQ;
  logic             mcandExtQ;
  logic             signQ;
  logic [PW-1:0]    prodQ;

  // operand conditioning at load
  logic             negMplier;
  logic [WIDTH-1:0] mcandLoad;
  logic [WIDTH-1:0] mplierLoad;
  logic             extLoad;

  always_comb begin
    negMplier  = signedMode & mplierIn[WIDTH-1];
    mcandLoad  = negMplier ? (~mcandIn + 1'b1) : mcandIn;
    mplierLoad = negMplier ? (~mplierIn + 1'b1) : mplierIn;
    if (!signedMode)     extLoad = 1'b0;
    else if (negMplier)  extLoad = (mcandIn != '0) & ~mcandIn[WIDTH-1];
    else                 extLoad = mcandIn[WIDTH-1];
  end

  // one step: conditional add into the upper half, then shift right
  logic [WIDTH-1:0] upper;
  logic             upperExt;
  logic [WIDTH:0]   sum;
  logic [WIDTH:0]   nextUpper;
  logic [PW-1:0]    shifted;

  always_comb begin
    upper     = prodQ[PW-1:WIDTH];
    upperExt  = signQ & upper[WIDTH-1];
    sum       = {upperExt, upper} + {mcandExtQ, mcandQ};
    nextUpper = prodQ[0] ? sum : {upperExt, upper};
    shifted   = {nextUpper, prodQ[WIDTH-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ    <= '0;
      mcandExtQ <= 1'b0;
      signQ     <= 1'b0;
      prodQ     <= '0;
    end else if (strobes.load) begin
      mcandQ    <= mcandLoad;
      mcandExtQ <= extLoad;
      signQ     <= signedMode;
      prodQ     <= {{WIDTH{1'b0}}, mplierLoad};
    end else if (strobes.step) begin
      prodQ <= shifted;
    end
  end

  assign prodHi = prodQ[PW-1:WIDTH];
  assign prodLo = prodQ[WIDTH-1:0];
endmodule

// File: rtl/seq_mul.sv
module seq_mul
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] mcandIn,
  input  logic [WIDTH-1:0] mplierIn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);
  mulStrobes_t strobes;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .signedMode (signedMode),
    .mcandIn    (mcandIn),
    .mplierIn   (mplierIn),
    .prodHi     (prodHi),
    .prodLo     (prodLo)
  );
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             signedMode,
  input logic [WIDTH-1:0] mcandIn,
  input logic [WIDTH-1:0] mplierIn,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] prodHi,
  input logic [WIDTH-1:0] prodLo
);
  localparam int PW = 2 * WIDTH;
  localparam int CW = $clog2(WIDTH + 2);

  logic [CW-1:0] busyCnt;
  logic [PW-1:0] expProd;
  logic signed [PW-1:0] sa;
  logic signed [PW-1:0] sb;

  always_comb begin
    sa = signedMode ? {{WIDTH{mcandIn[WIDTH-1]}}, mcandIn} : {{WIDTH{1'b0}}, mcandIn};
    sb = signedMode ? {{WIDTH{mplierIn[WIDTH-1]}}, mplierIn} : {{WIDTH{1'b0}}, mplierIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      expProd <= '0;
    end else if (start && !busy) begin
      busyCnt <= '0;
      expProd <= sa * sb;
    end else if (busy) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);                                   // R2
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyCnt == CW'(WIDTH));                            // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                            // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));                             // R3
  AST_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> {prodHi, prodLo} == expProd);                      // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> $stable(prodHi) && $stable(prodLo));    // R8
endmodule

bind seq_mul seq_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .signedMode (signedMode),
  .mcandIn    (mcandIn),
  .mplierIn   (mplierIn),
  .busy       (busy),
  .done       (done),
  .prodHi     (prodHi),
  .prodLo     (prodLo)
);

// File: tb/test_seq_mul.sv
module test_seq_mul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] mcandIn = '0;
  logic [31:0] mplierIn = '0;
  logic        busy;
  logic        done;
  logic [31:0] prodHi;
  logic [31:0] prodLo;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seq_mul i_seq_mul (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .mcandIn(mcandIn), .mplierIn(mplierIn),
    .busy(busy), .done(done), .prodHi(prodHi), .prodLo(prodLo)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] refMul(input logic [31:0] a, input logic [31:0] b,
                                         input logic s);
    longint sa;
    longint sb;
    logic [63:0] ua;
    logic [63:0] ub;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    ua = {32'b0, a};
    ub = {32'b0, b};
    return ua * ub;
  endfunction

  // One operation; reference model tracks busy/done per cycle.
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input bit poke, input string req);
    logic [63:0] exp;
    exp = refMul(a, b, s);
    @(negedge clk);
    start = 1'b1; mcandIn = a; mplierIn = b; signedMode = s;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 32; i++) begin
      chk(busy === 1'b1 && done === 1'b0, "R2/R3 busy window",
          {62'b0, busy, done}, 64'd2);
      if (poke && i == 4) begin   // R7: intrusion while busy
        start = 1'b1; mcandIn = ~a; mplierIn = b + 32'd3; signedMode = ~s;
      end
      if (poke && i == 6) start = 1'b0;
      @(negedge clk);
    end
    chk(busy === 1'b0 && done === 1'b1, "R3 done pulse", {62'b0, busy, done}, 64'd1);
    chk({prodHi, prodLo} === exp, req, {prodHi, prodLo}, exp);
    if (poke) chk({prodHi, prodLo} === exp, "R7 start ignored", {prodHi, prodLo}, exp);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R3 done one cycle", {62'b0, busy, done}, 64'd0);
    mcandIn = 32'h1234_5678; mplierIn = 32'h9abc_def0;
    @(negedge clk);
    chk({prodHi, prodLo} === exp, "R8 result held", {prodHi, prodLo}, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", {62'b0, busy, done}, 64'd0);
    chk({prodHi, prodLo} === 64'd0, "R1 reset product", {prodHi, prodLo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 after release", {62'b0, busy, done}, 64'd0);

    runOp(32'd13, 32'd11, 1'b0, 1'b0, "R4 unsigned small");
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 unsigned all ones");
    runOp(32'd0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R4 zero multiplicand");
    runOp(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R4 unsigned top bits");
    runOp(32'hFFFF_FFFD, 32'd11, 1'b1, 1'b0, "R5 negative mcand");
    runOp(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, "R5 min times max");
    runOp(32'hFFFF_FFFB, 32'hFFFF_FFF9, 1'b1, 1'b0, "R6 both negative");
    runOp(32'd7, 32'h8000_0000, 1'b1, 1'b0, "R6 min multiplier");
    runOp(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R6 min squared");
    runOp(32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6 zero mcand neg mplier");
    runOp(32'hFFFF_FFFF, 32'd2, 1'b0, 1'b0, "R9 unsigned interpretation");
    runOp(32'hFFFF_FFFF, 32'd2, 1'b1, 1'b0, "R9 signed interpretation");
    runOp(32'h0001_2345, 32'hFFFF_0000, 1'b1, 1'b1, "R7 signed with intrusion");
    runOp(32'hCAFE_F00D, 32'h0BAD_BEEF, 1'b0, 1'b1, "R7 unsigned with intrusion");
    for (int k = 0; k < 24; k++) begin
      runOp($urandom, $urandom, k[0], k[2], k[0] ? "R5/R6 random signed" : "R4 random unsigned");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule